// File: doc/BRIEF.md
# Bit-Serial CRC Engine with Byte Register Access

This block computes a cyclic redundancy check one bit at a time in a linear feedback shift register. The register width is a parameter of 8, 16, 24 or 32 bits. A wider engine acts as a chain of byte slices that share one serial input and one serial output. Software sets up the engine through a byte-wide register port. Each slice has three registers: an accumulator byte, a polynomial byte and a seed/result byte. A single control register holds the run bit.

To use the engine, software first writes the generator polynomial. The x^0 term is implied, and polynomial bit k is the coefficient of x^(k+1). While the run bit is clear, software writes the seed; each seed write also lands in the accumulator. Software then sets the run bit and supplies one data bit per strobe of the processing enable. The accumulator MSB is driven out serially. An interrupt pulses when the accumulator first matches the seed/result register. After the run bit is cleared, software reads the residue byte by byte in two steps. The accumulator byte always reads as zero, and that read arms the next read of the matching seed/result byte to return the residue.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, the run bit, all polynomial, seed and accumulator bytes, `bus_rdata`, `ser_out` and `irq` are zero.
- R2: While the run bit is 0, `ser_out` and `irq` stay low.
- R3: A write to a seed/result byte while the run bit is 0 also loads that accumulator byte. While the run bit is 1, the same write changes only the seed/result register.
- R4: On a clock with the run bit at 1 and `bit_en` at 1, let f = acc[MSB] xor `bit_in`. The accumulator becomes (acc << 1) xor (f ? {poly[W-2:0],1} : 0). The 16-bit polynomial 0x8810 with seed 0xFFFF over the ASCII bytes "123456789", MSB first, gives 0x29B1.
- R5: With `bit_en` at 0, the accumulator does not change.
- R6: While the run bit is 1, `ser_out` equals the accumulator MSB.
- R7: `irq` is a one-cycle pulse in the cycle after the accumulator first becomes equal to the seed/result register while running. Setting the run bit when the two are already equal gives no pulse.
- R8: Any read of an accumulator byte returns 0.
- R9: A read of accumulator byte b with the run bit at 0 captures that byte. The next read of seed/result byte b returns the captured value. A seed/result read that has no armed capture returns the seed byte.
- R10: `bus_rdata` changes only on the clock edge that samples `bus_rd`, and it holds its value otherwise.
- R11: An accumulator read while the run bit is 1 arms nothing. The next seed/result read returns the seed byte.
- R12: The address is {slice[1:0], kind[1:0]}, with kind 0 = accumulator, 1 = polynomial, 2 = seed/result, 3 = control. Control exists only at address 3, and its bit 0 is the run bit. Every other address with kind 3, and every slice at or beyond W/8, reads 0.
- R13: Each slice holds its own polynomial byte: slice b maps to bits 8b+7..8b. Each byte can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 4 | Register address {slice, kind} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bit_en | input | 1 | Processing enable; one LFSR step per cycle where set |
| bit_in | input | 1 | Serial data input |
| ser_out | output | 1 | Accumulator MSB while running, else 0 |
| irq | output | 1 | Compare-match pulse |

## Verification
The hardest condition to reach from the ports is the compare interrupt. The accumulator can only be loaded with the seed while the engine is stopped, so accumulator and seed start out equal. Making them equal again later takes many shifts. The bench therefore loads a zero seed and starts the engine, which must give no pulse. It then uses its own model to compute the accumulator value a chosen bit pattern will produce, and writes that value into the seed register while running. That write must leave the accumulator untouched. The bench then shifts the pattern and expects exactly one pulse, right after the matching step.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;
  // Low two address bits select the register kind inside a slice.
  typedef enum logic [1:0] {
    K_ACC  = 2'd0,
    K_POLY = 2'd1,
    K_SEED = 2'd2,
    K_CTRL = 2'd3
  } reg_kind_e;

  localparam int SLICE_AW = 2;
  localparam int BUS_AW   = SLICE_AW + 2;
endpackage

// File: rtl/crc_ser_regs.sv
module crc_ser_regs
  import crc_ser_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              run,
  output logic [WIDTH-1:0]  poly,
  output logic [WIDTH-1:0]  seed,
  output logic [WIDTH/8-1:0] seed_wr_mask
);
  localparam int NB = WIDTH / 8;

  logic [SLICE_AW-1:0] wr_slice;
  reg_kind_e           wr_kind;
  logic                run_q, run_d;

  assign wr_slice = bus_addr[BUS_AW-1:2];
  assign wr_kind  = reg_kind_e'(bus_addr[1:0]);

  always_comb begin
    run_d = run_q;
    if (bus_wr && (wr_slice == '0) && (wr_kind == K_CTRL)) run_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  assign run = run_q;

  for (genvar b = 0; b < NB; b++) begin : g_slice
    logic       hit, poly_we, seed_we;
    logic [7:0] poly_q, seed_q;

    assign hit     = bus_wr && (wr_slice == SLICE_AW'(b));
    assign poly_we = hit && (wr_kind == K_POLY);
    assign seed_we = hit && (wr_kind == K_SEED);

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        poly_q <= 8'h00;
        seed_q <= 8'h00;
      end else begin
        if (poly_we) poly_q <= bus_wdata;
        if (seed_we) seed_q <= bus_wdata;
      end
    end

    assign poly[8*b +: 8]  = poly_q;
    assign seed[8*b +: 8]  = seed_q;
    assign seed_wr_mask[b] = seed_we;
  end

endmodule

// File: rtl/crc_ser_lfsr.sv
module crc_ser_lfsr #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               run,
  input  logic               bit_en,
  input  logic               bit_in,
  input  logic [WIDTH-2:0]   poly_lo,
  input  logic [WIDTH-1:0]   seed,
  input  logic [WIDTH/8-1:0] seed_wr_mask,
  input  logic [7:0]         bus_wdata,
  output logic [WIDTH-1:0]   acc,
  output logic               irq
);
  localparam int NB = WIDTH / 8;

  logic [WIDTH-1:0] acc_q, acc_d, stepped;
  logic             fb, eq, eq_q;

  always_comb begin
    fb      = acc_q[WIDTH-1] ^ bit_in;
    stepped = {acc_q[WIDTH-2:0], 1'b0} ^ ({WIDTH{fb}} & {poly_lo, 1'b1});
    acc_d   = acc_q;
    if (run) begin
      if (bit_en) acc_d = stepped;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (seed_wr_mask[b]) acc_d[8*b +: 8] = bus_wdata;
      end
    end
  end

  assign eq = (acc_q == seed);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      eq_q  <= eq;
    end
  end

  assign acc = acc_q;
  assign irq = run & eq & ~eq_q;

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && (seed_wr_mask == '0)) |=> $stable(acc_q));

  // R5
  bit_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !bit_en) |=> $stable(acc_q));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |=> !irq);

endmodule

// File: rtl/crc_ser_rdback.sv
module crc_ser_rdback
  import crc_ser_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [WIDTH-1:0]  acc,
  input  logic [WIDTH-1:0]  poly,
  input  logic [WIDTH-1:0]  seed,
  output logic [7:0]        rdata
);
  localparam int NB = WIDTH / 8;

  logic [SLICE_AW-1:0] rd_slice;
  reg_kind_e           rd_kind;
  logic [7:0]          rdata_q, rdata_d;
  logic [NB-1:0]       armed_q, armed_d;
  logic [WIDTH-1:0]    hold_q, hold_d;

  assign rd_slice = bus_addr[BUS_AW-1:2];
  assign rd_kind  = reg_kind_e'(bus_addr[1:0]);

  always_comb begin
    rdata_d = rdata_q;
    armed_d = armed_q;
    hold_d  = hold_q;
    if (bus_rd) begin
      rdata_d = 8'h00;
      for (int b = 0; b < NB; b++) begin
        if (int'(rd_slice) == b) begin
          case (rd_kind)
            K_ACC: begin
              if (!run) begin
                hold_d[8*b +: 8] = acc[8*b +: 8];
                armed_d[b]       = 1'b1;
              end
            end
            K_POLY: rdata_d = poly[8*b +: 8];
            K_SEED: begin
              if (armed_q[b]) begin
                rdata_d    = hold_q[8*b +: 8];
                armed_d[b] = 1'b0;
              end else begin
                rdata_d = seed[8*b +: 8];
              end
            end
            K_CTRL: if (b == 0) rdata_d = {7'b0, run};
            default: rdata_d = 8'h00;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= 8'h00;
      armed_q <= '0;
      hold_q  <= '0;
    end else begin
      rdata_q <= rdata_d;
      armed_q <= armed_d;
      hold_q  <= hold_d;
    end
  end

  assign rdata = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_rd |=> $stable(rdata_q));

  // R8
  acc_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && (rd_kind == K_ACC)) |=> (rdata_q == 8'h00));

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_ser_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              ser_out,
  output logic              irq
);
  localparam int NB = WIDTH / 8;

  if ((WIDTH % 8 != 0) || (WIDTH < 8) || (WIDTH > 32)) begin : g_bad_width
    $error("WIDTH must be 8, 16, 24 or 32");
  end

  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             run;
  logic [WIDTH-1:0] poly, seed, acc;
  logic [NB-1:0]    seed_wr_mask;
  logic             irq_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_i_n = rst_sync_q[1];

  crc_ser_regs #(.WIDTH(WIDTH)) u_regs (
    .clk          (clk),
    .rst_ni       (rst_i_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .run          (run),
    .poly         (poly),
    .seed         (seed),
    .seed_wr_mask (seed_wr_mask)
  );

  crc_ser_lfsr #(.WIDTH(WIDTH)) u_lfsr (
    .clk          (clk),
    .rst_ni       (rst_i_n),
    .run          (run),
    .bit_en       (bit_en),
    .bit_in       (bit_in),
    .poly_lo      (poly[WIDTH-2:0]),
    .seed         (seed),
    .seed_wr_mask (seed_wr_mask),
    .bus_wdata    (bus_wdata),
    .acc          (acc),
    .irq          (irq_raw)
  );

  crc_ser_rdback #(.WIDTH(WIDTH)) u_rdback (
    .clk      (clk),
    .rst_ni   (rst_i_n),
    .run      (run),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .acc      (acc),
    .poly     (poly),
    .seed     (seed),
    .rdata    (bus_rdata)
  );

  assign ser_out = run & acc[WIDTH-1];
  assign irq     = irq_raw;

  // R2
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !run |-> (!ser_out && !irq));

endmodule

// File: tb/tb_crc_serial_engine.sv
module tb_crc_serial_engine;
  localparam int W = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd, bit_en, bit_in;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ser_out, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  crc_serial_engine #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bit_en(bit_en), .bit_in(bit_in), .ser_out(ser_out), .irq(irq)
  );

  // Address map for a 16-bit engine: {slice, kind}
  localparam logic [3:0] A_ACC0 = 4'h0, A_POLY0 = 4'h1, A_SEED0 = 4'h2, A_CTRL = 4'h3;
  localparam logic [3:0] A_ACC1 = 4'h4, A_POLY1 = 4'h5, A_SEED1 = 4'h6, A_CTRL1 = 4'h7;
  localparam logic [3:0] A_SLICE2_POLY = 4'h9;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_step(logic [15:0] a, logic [15:0] p, logic b);
    logic f;
    f = a[15] ^ b;
    return {a[14:0], 1'b0} ^ (f ? {p[14:0], 1'b1} : 16'h0000);
  endfunction

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic shift_bit(logic b);
    @(negedge clk);
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic read_residue(output logic [15:0] r);
    logic [7:0] d;
    bus_read(A_ACC0, d);
    check("R8 acc0 reads zero", d, 8'h00);
    bus_read(A_SEED0, d);
    r[7:0] = d;
    bus_read(A_ACC1, d);
    check("R8 acc1 reads zero", d, 8'h00);
    bus_read(A_SEED1, d);
    r[15:8] = d;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 ser_out after reset", ser_out, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 rdata after reset", bus_rdata, 0);
    bus_read(A_CTRL, d);  check("R1 run bit reset", d, 0);
    bus_read(A_POLY1, d); check("R1 poly1 reset", d, 0);
    bus_read(A_SEED0, d); check("R1 seed0 reset", d, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    bus_write(A_POLY0, 8'h5A);
    bus_write(A_POLY1, 8'hC3);
    bus_read(A_POLY0, d); check("R13 poly slice0", d, 8'h5A);
    bus_read(A_POLY1, d); check("R13 poly slice1", d, 8'hC3);
    bus_read(A_SLICE2_POLY, d); check("R12 absent slice reads zero", d, 8'h00);
    bus_write(A_CTRL, 8'h01);
    bus_read(A_CTRL, d);  check("R12 run bit readback", d, 8'h01);
    bus_read(A_CTRL1, d); check("R12 kind3 on slice1 reads zero", d, 8'h00);
    bus_write(A_CTRL, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 rdata held without read", bus_rdata, 8'h00);
  endtask

  task automatic t_ccitt();
    logic [15:0] m, r;
    logic [7:0]  d;
    logic [71:0] msg;
    msg = "123456789";
    bus_write(A_POLY0, 8'h10);
    bus_write(A_POLY1, 8'h88);
    bus_write(A_SEED0, 8'hFF);
    bus_write(A_SEED1, 8'hFF);
    read_residue(r);
    check("R3 seed write loads acc while stopped", r, 16'hFFFF);
    bus_write(A_CTRL, 8'h01);
    check("R6 ser_out follows msb", ser_out, 1);
    m = 16'hFFFF;
    for (int i = 71; i >= 0; i--) begin
      shift_bit(msg[i]);
      m = model_step(m, 16'h8810, msg[i]);
      check("R6 ser_out per bit", ser_out, m[15]);
    end
    bus_write(A_CTRL, 8'h00);
    check("R2 ser_out low when stopped", ser_out, 0);
    read_residue(r);
    check("R4 CCITT residue", r, 16'h29B1);
    check("R9 model residue", r, m);
    bus_read(A_SEED0, d);
    check("R9 unarmed seed read returns seed", d, 8'hFF);
  endtask

  task automatic t_gate_and_enabled_seed();
    logic [15:0] r;
    logic [7:0]  d;
    bus_write(A_SEED0, 8'h34);
    bus_write(A_SEED1, 8'h92);
    bus_write(A_CTRL, 8'h01);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_in = i[0];
    end
    bus_write(A_SEED0, 8'h00);
    bus_read(A_ACC0, d);
    check("R8 acc read while running", d, 8'h00);
    bus_read(A_SEED0, d);
    check("R11 running acc read arms nothing", d, 8'h00);
    check("R6 ser_out high msb", ser_out, 1);
    bus_write(A_CTRL, 8'h00);
    check("R2 ser_out low with msb set", ser_out, 0);
    read_residue(r);
    check("R5 R3 acc unchanged", r, 16'h9234);
  endtask

  task automatic t_irq();
    logic [15:0] m, prev, target;
    logic [7:0]  pat;
    pat = 8'hB6;
    bus_write(A_SEED0, 8'h00);
    bus_write(A_SEED1, 8'h00);
    bus_write(A_CTRL, 8'h01);
    check("R7 no pulse when starting equal", irq, 0);
    @(negedge clk);
    check("R7 no pulse one cycle later", irq, 0);
    target = 16'h0000;
    for (int i = 7; i >= 0; i--) target = model_step(target, 16'h8810, pat[i]);
    bus_write(A_SEED0, target[7:0]);
    bus_write(A_SEED1, target[15:8]);
    m = 16'h0000;
    for (int i = 7; i >= 0; i--) begin
      prev = m;
      m = model_step(m, 16'h8810, pat[i]);
      shift_bit(pat[i]);
      check("R7 irq after step", irq, (m == target) && (prev != target));
    end
    @(negedge clk);
    check("R7 irq single cycle", irq, 0);
    bus_write(A_CTRL, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    bit_en = 0; bit_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_ccitt();
    t_gate_and_enabled_seed();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule